// File: doc/BRIEF.md
# NAND DMA Command Intake Sequencer

This block sits between the host write path of a NAND flash controller and its DMA engine. It accepts DMA commands in either of two forms and turns each complete, valid command into one descriptor of `SLICES` half-words. The first form is a multi-transaction set: for each slice the host writes a command word that carries the slice index, then a data word that carries the slice contents. The second form is one incrementing burst of `SLICES` 16-bit beats. Both forms build the same descriptor layout.

While DMA mode is on, the block enforces the ordering rules. A set must arrive without interruption. Only page-operation commands may pass between complete sets, and all other command classes are refused. The burst-size field of every descriptor is checked, and a new set is refused while an earlier descriptor is still waiting for the engine. Each refusal raises a one-cycle error pulse that names its cause.

After the engine takes a descriptor, the block tracks the transfer until the engine reports it done. It then sets a sticky completion status bit. If the descriptor asked for a host interrupt, the interrupt line is also raised. Requests to change the DMA cache attributes are applied only while the engine is idle. A request made while the engine is busy is held and applied later, or, in the flag variant, refused with an error.

Top module: `nand_dma_intake`

## Requirements
- R1: In a multi-transaction set, command word k (data bits [1:0] = k, `wr_phase`=0) is followed by its data word (`wr_phase`=1), for k = 0..3 in order. The data word of pair k lands in `desc_data[16k+15:16k]`. `desc_valid` rises in the cycle after the last data word.
- R2: During an open set or burst, the set is dropped, the sequencer returns to idle and `err_seq` pulses for one cycle if any of these arrive: a non-DMA write, a burst beat, a word of the wrong phase, or a command word with the wrong index. A data word, a nonzero-index command word or a nonzero burst beat that arrives while idle also raises `err_seq`.
- R3: A write with `wr_dma`=0 that arrives between complete sets is forwarded. `fwd_valid` pulses for one cycle with no error. When DMA mode is on, this applies only to the page class (`wr_class`=2'b10).
- R4: With `dma_mode`=1, a write of class 2'b00, 2'b01 or 2'b11 raises `err_class` and leaves any open set untouched. With `dma_mode`=0, a DMA command word or a burst beat raises `err_class`.
- R5: In burst form, beats arrive on `bst_beat` 0,1,2,3 in ascending order. Beat k lands in slice k, so the descriptor layout is identical to R1.
- R6: The size field `desc_data[7:0]` must be 4, 16, 32 or 64. Any other value raises `err_size` when the set completes, and no descriptor is produced.
- R7: `desc_valid` and `desc_data` hold steady until the cycle in which `desc_ready` is high.
- R8: A set start (command word index 0 or burst beat 0) that arrives while `desc_valid` is high raises `err_busy` and is discarded.
- R9: A pulse on `eng_done` while a transfer is in flight sets `done_sts` in the next cycle. `irq` follows only if the INT bit `desc_data[8]` of that transfer was 1. A pulse on `eng_done` with no transfer in flight has no effect.
- R10: A pulse on `clr_done` clears `done_sts` and `irq` (write-one-to-clear). Until then `irq` stays high.
- R11: A `cache_req` made while the engine is idle (no descriptor waiting, no transfer in flight) updates `cache_attr` in the next cycle. A request made while busy leaves `cache_attr` unchanged, sets `cache_pend`, and is applied once the engine is idle again.
- R12: At most one of `err_seq`, `err_class`, `err_size`, `err_busy` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dma_mode | input | 1 | DMA mode enable |
| wr_valid | input | 1 | Host command-path write strobe |
| wr_class | input | 2 | Command class of the write |
| wr_dma | input | 1 | Write belongs to a DMA command set |
| wr_phase | input | 1 | 0 = command word, 1 = data word |
| wr_data | input | SLICE_W | Write payload |
| bst_valid | input | 1 | Burst beat strobe |
| bst_beat | input | log2(SLICES) | Beat position within the burst |
| bst_data | input | SLICE_W | Beat payload |
| fwd_valid | output | 1 | Non-DMA command accepted |
| err_seq | output | 1 | Ordering error pulse |
| err_class | output | 1 | Illegal class error pulse |
| err_size | output | 1 | Invalid burst size pulse |
| err_busy | output | 1 | Descriptor still pending pulse |
| desc_valid | output | 1 | Descriptor offered to engine |
| desc_data | output | SLICE_W*SLICES | Descriptor contents |
| desc_ready | input | 1 | Engine takes the descriptor |
| eng_done | input | 1 | Engine transfer complete |
| done_sts | output | 1 | Sticky completion status |
| clr_done | input | 1 | Write-one-to-clear for `done_sts` |
| irq | output | 1 | Host interrupt, level |
| cache_req | input | 1 | Cache attribute update request |
| cache_val | input | CACHE_W | Requested cache attributes |
| cache_attr | output | CACHE_W | Applied cache attributes |
| cache_pend | output | 1 | Deferred update waiting |
| err_cache | output | 1 | Update refused (flag variant only) |

## Verification
The properties assume that `wr_valid` and `bst_valid` are never high in the same cycle, and that `dma_mode` changes only while no set is open. The bench drives one strobe per cycle and changes the mode only between sets, after a reset or after a completed or refused set. `eng_done` is pulsed only after a descriptor has been taken. The one exception is a deliberate stray pulse that exercises the no-effect case. `clr_done` is never driven in the same cycle as `eng_done`.

// File: rtl/nand_dma_pkg.sv
package nand_dma_pkg;

   localparam logic [1:0] CLS_PAGE = 2'b10;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_MT_DATA = 2'd1,
      ST_MT_CMD  = 2'd2,
      ST_BURST   = 2'd3
   } intake_st_e;

   typedef struct packed {
      logic seq;
      logic cls;
      logic size;
      logic busy;
   } intake_err_t;

   function automatic logic size_legal(input logic [7:0] sz);
      return (sz == 8'd4) || (sz == 8'd16) || (sz == 8'd32) || (sz == 8'd64);
   endfunction

endpackage

// File: rtl/nand_dma_intake_seq.sv
module nand_dma_intake_seq
   import nand_dma_pkg::*;
#(
   parameter int SLICE_W  = 16,
   parameter int SLICES   = 4,
   parameter int SIZE_LSB = 0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        dma_mode,
   input  logic                        wr_valid,
   input  logic [1:0]                  wr_class,
   input  logic                        wr_dma,
   input  logic                        wr_phase,
   input  logic [SLICE_W-1:0]          wr_data,
   input  logic                        bst_valid,
   input  logic [$clog2(SLICES)-1:0]   bst_beat,
   input  logic [SLICE_W-1:0]          bst_data,
   input  logic                        desc_pending,
   output logic                        new_desc,
   output logic [SLICE_W*SLICES-1:0]   asm_desc,
   output logic                        fwd_valid,
   output intake_err_t                 err
);
   localparam int IDX_W = $clog2(SLICES);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(SLICES - 1);
   localparam logic [IDX_W-1:0] ONE  = IDX_W'(1);

   intake_st_e        st_q, st_d;
   logic [IDX_W-1:0]  idx_q, idx_d;
   logic [SLICE_W-1:0] slice_q [SLICES];
   logic              store, finish, fwd_d;
   logic [SLICE_W-1:0] store_data;
   intake_err_t       err_d, err_q;
   logic              fwd_q;

   for (genvar k = 0; k < SLICES; k++) begin : g_asm
      if (k == SLICES - 1) begin : g_last
         assign asm_desc[k*SLICE_W +: SLICE_W] = store_data;
      end else begin : g_held
         assign asm_desc[k*SLICE_W +: SLICE_W] = slice_q[k];
      end
   end

   always_comb begin
      st_d       = st_q;
      idx_d      = idx_q;
      store      = 1'b0;
      finish     = 1'b0;
      fwd_d      = 1'b0;
      err_d      = '0;
      store_data = wr_data;
      if (wr_valid) begin
         if (!dma_mode) begin
            if (wr_dma) err_d.cls = 1'b1;
            else        fwd_d     = 1'b1;
         end else if (wr_class != CLS_PAGE) begin
            err_d.cls = 1'b1;
         end else if (!wr_dma) begin
            if (st_q != ST_IDLE) begin
               err_d.seq = 1'b1;
               st_d      = ST_IDLE;
               idx_d     = '0;
            end else begin
               fwd_d = 1'b1;
            end
         end else if (!wr_phase) begin
            if (st_q == ST_IDLE && wr_data[IDX_W-1:0] == '0) begin
               if (desc_pending) err_d.busy = 1'b1;
               else              st_d       = ST_MT_DATA;
            end else if (st_q == ST_MT_CMD && wr_data[IDX_W-1:0] == idx_q) begin
               st_d = ST_MT_DATA;
            end else begin
               err_d.seq = 1'b1;
               st_d      = ST_IDLE;
               idx_d     = '0;
            end
         end else begin
            if (st_q == ST_MT_DATA) begin
               store = 1'b1;
               if (idx_q == LAST) begin
                  finish = 1'b1;
               end else begin
                  st_d  = ST_MT_CMD;
                  idx_d = idx_q + ONE;
               end
            end else begin
               err_d.seq = 1'b1;
               st_d      = ST_IDLE;
               idx_d     = '0;
            end
         end
      end else if (bst_valid) begin
         store_data = bst_data;
         if (!dma_mode) begin
            err_d.cls = 1'b1;
         end else if (st_q == ST_IDLE && bst_beat == '0) begin
            if (desc_pending) begin
               err_d.busy = 1'b1;
            end else begin
               store = 1'b1;
               st_d  = ST_BURST;
               idx_d = ONE;
            end
         end else if (st_q == ST_BURST && bst_beat == idx_q) begin
            store = 1'b1;
            if (idx_q == LAST) finish = 1'b1;
            else               idx_d  = idx_q + ONE;
         end else begin
            err_d.seq = 1'b1;
            st_d      = ST_IDLE;
            idx_d     = '0;
         end
      end
      if (finish) begin
         st_d  = ST_IDLE;
         idx_d = '0;
         if (!size_legal(asm_desc[SIZE_LSB +: 8])) err_d.size = 1'b1;
      end
   end

   assign new_desc = finish && !err_d.size;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         idx_q <= '0;
         err_q <= '0;
         fwd_q <= 1'b0;
         for (int k = 0; k < SLICES; k++) slice_q[k] <= '0;
      end else begin
         st_q  <= st_d;
         idx_q <= idx_d;
         err_q <= err_d;
         fwd_q <= fwd_d;
         if (store) slice_q[idx_q] <= store_data;
      end
   end

   assign err       = err_q;
   assign fwd_valid = fwd_q;

endmodule

// File: rtl/nand_dma_desc_port.sv
module nand_dma_desc_port #(
   parameter int DESC_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              new_desc,
   input  logic [DESC_W-1:0] desc_in,
   input  logic              desc_ready,
   output logic              desc_valid,
   output logic [DESC_W-1:0] desc_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         desc_valid <= 1'b0;
         desc_data  <= '0;
      end else if (new_desc) begin
         desc_valid <= 1'b1;
         desc_data  <= desc_in;
      end else if (desc_valid && desc_ready) begin
         desc_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/nand_dma_done_ctl.sv
module nand_dma_done_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic handoff,
   input  logic handoff_int,
   input  logic desc_valid,
   input  logic eng_done,
   input  logic clr_done,
   output logic done_sts,
   output logic irq,
   output logic eng_idle
);
   logic active_q, int_q, done_q, sel_q;
   logic finish;

   assign finish = eng_done && active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         int_q    <= 1'b0;
         done_q   <= 1'b0;
         sel_q    <= 1'b0;
      end else begin
         if (handoff) begin
            active_q <= 1'b1;
            int_q    <= handoff_int;
         end else if (finish) begin
            active_q <= 1'b0;
         end
         if (finish) begin
            done_q <= 1'b1;
            sel_q  <= (done_q && sel_q) || int_q;
         end else if (clr_done) begin
            done_q <= 1'b0;
            sel_q  <= 1'b0;
         end
      end
   end

   assign done_sts = done_q;
   assign irq      = done_q && sel_q;
   assign eng_idle = !active_q && !desc_valid;
endmodule

// File: rtl/nand_dma_cache_guard.sv
module nand_dma_cache_guard #(
   parameter int              CACHE_W   = 4,
   parameter logic [CACHE_W-1:0] CACHE_RST = '0,
   parameter bit              DEFER     = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               eng_idle,
   input  logic               cache_req,
   input  logic [CACHE_W-1:0] cache_val,
   output logic [CACHE_W-1:0] cache_attr,
   output logic               cache_pend,
   output logic               err_cache
);
   logic [CACHE_W-1:0] attr_q;
   assign cache_attr = attr_q;

   if (DEFER) begin : g_defer
      logic               pend_q;
      logic [CACHE_W-1:0] pval_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            attr_q <= CACHE_RST;
            pend_q <= 1'b0;
            pval_q <= '0;
         end else if (cache_req) begin
            if (eng_idle) begin
               attr_q <= cache_val;
               pend_q <= 1'b0;
            end else begin
               pend_q <= 1'b1;
               pval_q <= cache_val;
            end
         end else if (pend_q && eng_idle) begin
            attr_q <= pval_q;
            pend_q <= 1'b0;
         end
      end
      assign cache_pend = pend_q;
      assign err_cache  = 1'b0;
   end else begin : g_flag
      logic err_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            attr_q <= CACHE_RST;
            err_q  <= 1'b0;
         end else begin
            err_q <= cache_req && !eng_idle;
            if (cache_req && eng_idle) attr_q <= cache_val;
         end
      end
      assign cache_pend = 1'b0;
      assign err_cache  = err_q;
   end
endmodule

// File: rtl/nand_dma_intake.sv
module nand_dma_intake
   import nand_dma_pkg::*;
#(
   parameter int                 SLICE_W   = 16,
   parameter int                 SLICES    = 4,
   parameter int                 SIZE_LSB  = 0,
   parameter int                 INT_BIT   = 8,
   parameter int                 CACHE_W   = 4,
   parameter logic [CACHE_W-1:0] CACHE_RST = '0,
   parameter bit                 DEFER_CACHE = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        dma_mode,
   input  logic                        wr_valid,
   input  logic [1:0]                  wr_class,
   input  logic                        wr_dma,
   input  logic                        wr_phase,
   input  logic [SLICE_W-1:0]          wr_data,
   input  logic                        bst_valid,
   input  logic [$clog2(SLICES)-1:0]   bst_beat,
   input  logic [SLICE_W-1:0]          bst_data,
   output logic                        fwd_valid,
   output logic                        err_seq,
   output logic                        err_class,
   output logic                        err_size,
   output logic                        err_busy,
   output logic                        desc_valid,
   output logic [SLICE_W*SLICES-1:0]   desc_data,
   input  logic                        desc_ready,
   input  logic                        eng_done,
   output logic                        done_sts,
   input  logic                        clr_done,
   output logic                        irq,
   input  logic                        cache_req,
   input  logic [CACHE_W-1:0]          cache_val,
   output logic [CACHE_W-1:0]          cache_attr,
   output logic                        cache_pend,
   output logic                        err_cache
);
   localparam int DESC_W = SLICE_W * SLICES;

   if (SLICES < 2 || (SLICES & (SLICES - 1)) != 0) begin : g_bad_slices
      $error("SLICES must be a power of two of at least 2");
   end
   if (SIZE_LSB + 8 > SLICE_W) begin : g_bad_size
      $error("size field must sit inside the first slice");
   end
   if (INT_BIT >= DESC_W || $clog2(SLICES) > SLICE_W) begin : g_bad_fields
      $error("field positions exceed descriptor width");
   end

   logic              new_desc, eng_idle;
   logic [DESC_W-1:0] asm_desc;
   intake_err_t       err;

   nand_dma_intake_seq #(
      .SLICE_W(SLICE_W), .SLICES(SLICES), .SIZE_LSB(SIZE_LSB)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode),
      .wr_valid(wr_valid), .wr_class(wr_class), .wr_dma(wr_dma),
      .wr_phase(wr_phase), .wr_data(wr_data),
      .bst_valid(bst_valid), .bst_beat(bst_beat), .bst_data(bst_data),
      .desc_pending(desc_valid), .new_desc(new_desc), .asm_desc(asm_desc),
      .fwd_valid(fwd_valid), .err(err)
   );

   assign err_seq   = err.seq;
   assign err_class = err.cls;
   assign err_size  = err.size;
   assign err_busy  = err.busy;

   nand_dma_desc_port #(.DESC_W(DESC_W)) port_i (
      .clk(clk), .rst_n(rst_n), .new_desc(new_desc), .desc_in(asm_desc),
      .desc_ready(desc_ready), .desc_valid(desc_valid), .desc_data(desc_data)
   );

   nand_dma_done_ctl done_i (
      .clk(clk), .rst_n(rst_n),
      .handoff(desc_valid && desc_ready), .handoff_int(desc_data[INT_BIT]),
      .desc_valid(desc_valid), .eng_done(eng_done), .clr_done(clr_done),
      .done_sts(done_sts), .irq(irq), .eng_idle(eng_idle)
   );

   nand_dma_cache_guard #(
      .CACHE_W(CACHE_W), .CACHE_RST(CACHE_RST), .DEFER(DEFER_CACHE)
   ) cache_i (
      .clk(clk), .rst_n(rst_n), .eng_idle(eng_idle),
      .cache_req(cache_req), .cache_val(cache_val),
      .cache_attr(cache_attr), .cache_pend(cache_pend), .err_cache(err_cache)
   );

endmodule

// File: rtl/nand_dma_intake_chk.sv
module nand_dma_intake_chk
   import nand_dma_pkg::*;
#(
   parameter int SLICE_W  = 16,
   parameter int SLICES   = 4,
   parameter int SIZE_LSB = 0,
   parameter int CACHE_W  = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      dma_mode,
   input logic                      wr_valid,
   input logic [1:0]                wr_class,
   input logic                      bst_valid,
   input logic [$clog2(SLICES)-1:0] bst_beat,
   input logic                      err_seq,
   input logic                      err_class,
   input logic                      err_size,
   input logic                      err_busy,
   input logic                      desc_valid,
   input logic [SLICE_W*SLICES-1:0] desc_data,
   input logic                      desc_ready,
   input logic                      eng_done,
   input logic                      done_sts,
   input logic                      clr_done,
   input logic                      irq,
   input logic [CACHE_W-1:0]        cache_attr,
   input logic                      eng_idle
);
   AST_DESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid && !desc_ready |=> desc_valid && $stable(desc_data)); // R7

   AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(desc_valid) |-> size_legal(desc_data[SIZE_LSB +: 8])); // R6

   AST_CLASS_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      dma_mode && wr_valid && wr_class != CLS_PAGE |=> err_class); // R4

   AST_BUSY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      dma_mode && desc_valid && bst_valid && !wr_valid && bst_beat == '0 |=> err_busy); // R8

   AST_ERR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_seq, err_class, err_size, err_busy})); // R12

   AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_sts) |-> $past(eng_done)); // R9

   AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_done && !eng_done |=> !done_sts && !irq); // R10

   AST_CACHE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_idle |=> $stable(cache_attr)); // R11
endmodule

bind nand_dma_intake nand_dma_intake_chk #(
   .SLICE_W(SLICE_W), .SLICES(SLICES), .SIZE_LSB(SIZE_LSB), .CACHE_W(CACHE_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode), .wr_valid(wr_valid),
   .wr_class(wr_class), .bst_valid(bst_valid), .bst_beat(bst_beat),
   .err_seq(err_seq), .err_class(err_class), .err_size(err_size),
   .err_busy(err_busy), .desc_valid(desc_valid), .desc_data(desc_data),
   .desc_ready(desc_ready), .eng_done(eng_done), .done_sts(done_sts),
   .clr_done(clr_done), .irq(irq), .cache_attr(cache_attr), .eng_idle(eng_idle)
);

// File: tb/nand_dma_intake_tb_top.sv
`timescale 1ns/1ps
module nand_dma_intake_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dma_mode = 1'b0;
   logic        wr_valid = 1'b0;
   logic [1:0]  wr_class = 2'b00;
   logic        wr_dma = 1'b0;
   logic        wr_phase = 1'b0;
   logic [15:0] wr_data = '0;
   logic        bst_valid = 1'b0;
   logic [1:0]  bst_beat = '0;
   logic [15:0] bst_data = '0;
   logic        fwd_valid, err_seq, err_class, err_size, err_busy;
   logic        desc_valid;
   logic [63:0] desc_data;
   logic        desc_ready = 1'b0;
   logic        eng_done = 1'b0;
   logic        done_sts;
   logic        clr_done = 1'b0;
   logic        irq;
   logic        cache_req = 1'b0;
   logic [3:0]  cache_val = '0;
   logic [3:0]  cache_attr;
   logic        cache_pend, err_cache;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   nand_dma_intake dut_i (
      .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode),
      .wr_valid(wr_valid), .wr_class(wr_class), .wr_dma(wr_dma),
      .wr_phase(wr_phase), .wr_data(wr_data),
      .bst_valid(bst_valid), .bst_beat(bst_beat), .bst_data(bst_data),
      .fwd_valid(fwd_valid), .err_seq(err_seq), .err_class(err_class),
      .err_size(err_size), .err_busy(err_busy),
      .desc_valid(desc_valid), .desc_data(desc_data), .desc_ready(desc_ready),
      .eng_done(eng_done), .done_sts(done_sts), .clr_done(clr_done), .irq(irq),
      .cache_req(cache_req), .cache_val(cache_val), .cache_attr(cache_attr),
      .cache_pend(cache_pend), .err_cache(err_cache)
   );

   // row: op[24:22] cls[21:20] phase[19] data[18:3] expect[2:0]
   // op: 1 non-DMA write, 2 DMA write, 3 burst beat (cls = beat), 4 desc_ready
   // expect: 0 quiet, 1 fwd, 2 seq, 3 class, 4 size, 5 busy, 6 desc up, 7 desc gone
   localparam int NV = 35;
   localparam logic [24:0] VEC [NV] = '{
      {3'd2, 2'd2, 1'b0, 16'h0000, 3'd0},
      {3'd2, 2'd2, 1'b1, 16'h0110, 3'd0},
      {3'd2, 2'd2, 1'b0, 16'h0001, 3'd0},
      {3'd2, 2'd2, 1'b1, 16'hAAAA, 3'd0},
      {3'd2, 2'd2, 1'b0, 16'h0002, 3'd0},
      {3'd2, 2'd2, 1'b1, 16'hBBBB, 3'd0},
      {3'd2, 2'd2, 1'b0, 16'h0003, 3'd0},
      {3'd2, 2'd2, 1'b1, 16'hCCCC, 3'd6},
      {3'd4, 2'd0, 1'b0, 16'h0000, 3'd7},
      {3'd1, 2'd2, 1'b0, 16'h1234, 3'd1},
      {3'd1, 2'd0, 1'b0, 16'h0000, 3'd3},
      {3'd1, 2'd3, 1'b0, 16'h0000, 3'd3},
      {3'd1, 2'd1, 1'b0, 16'h0000, 3'd3},
      {3'd2, 2'd2, 1'b0, 16'h0000, 3'd0},
      {3'd1, 2'd2, 1'b0, 16'h0000, 3'd2},
      {3'd2, 2'd2, 1'b1, 16'h5555, 3'd2},
      {3'd2, 2'd2, 1'b0, 16'h0001, 3'd2},
      {3'd3, 2'd0, 1'b0, 16'h0005, 3'd0},
      {3'd3, 2'd1, 1'b0, 16'h1111, 3'd0},
      {3'd3, 2'd2, 1'b0, 16'h2222, 3'd0},
      {3'd3, 2'd3, 1'b0, 16'h3333, 3'd4},
      {3'd3, 2'd0, 1'b0, 16'h0040, 3'd0},
      {3'd3, 2'd2, 1'b0, 16'h0000, 3'd2},
      {3'd2, 2'd2, 1'b0, 16'h0000, 3'd0},
      {3'd2, 2'd2, 1'b1, 16'h0004, 3'd0},
      {3'd3, 2'd0, 1'b0, 16'h0000, 3'd2},
      {3'd2, 2'd2, 1'b0, 16'h0000, 3'd0},
      {3'd2, 2'd2, 1'b0, 16'h0000, 3'd2},
      {3'd3, 2'd0, 1'b0, 16'h0020, 3'd0},
      {3'd3, 2'd1, 1'b0, 16'h0001, 3'd0},
      {3'd3, 2'd2, 1'b0, 16'h0002, 3'd0},
      {3'd3, 2'd3, 1'b0, 16'h0003, 3'd6},
      {3'd2, 2'd2, 1'b0, 16'h0000, 3'd5},
      {3'd3, 2'd0, 1'b0, 16'h0000, 3'd5},
      {3'd4, 2'd0, 1'b0, 16'h0000, 3'd7}
   };

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_wr(input logic [1:0] cls, input logic dma, input logic ph, input logic [15:0] d);
      wr_valid = 1'b1; wr_class = cls; wr_dma = dma; wr_phase = ph; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic do_bst(input logic [1:0] beat, input logic [15:0] d);
      bst_valid = 1'b1; bst_beat = beat; bst_data = d;
      @(negedge clk);
      bst_valid = 1'b0;
   endtask

   task automatic pulse_ready();
      desc_ready = 1'b1; @(negedge clk); desc_ready = 1'b0;
   endtask

   task automatic pulse_done();
      eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
   endtask

   task automatic pulse_clr();
      clr_done = 1'b1; @(negedge clk); clr_done = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic mt_set(input logic [15:0] s0, s1, s2, s3);
      do_wr(2'd2, 1'b1, 1'b0, 16'h0000); do_wr(2'd2, 1'b1, 1'b1, s0);
      do_wr(2'd2, 1'b1, 1'b0, 16'h0001); do_wr(2'd2, 1'b1, 1'b1, s1);
      do_wr(2'd2, 1'b1, 1'b0, 16'h0002); do_wr(2'd2, 1'b1, 1'b1, s2);
      do_wr(2'd2, 1'b1, 1'b0, 16'h0003); do_wr(2'd2, 1'b1, 1'b1, s3);
   endtask

   initial begin
      #(20 * 100000);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check(!desc_valid && !done_sts && !irq && !cache_pend, "RST outputs",
            {60'd0, desc_valid, done_sts, irq, cache_pend}, 64'd0);
      check(cache_attr == 4'd0, "RST cache_attr", 64'(cache_attr), 64'd0);

      dma_mode = 1'b1;
      for (int i = 0; i < NV; i++) begin
         logic [24:0] v;
         logic [4:0]  ef, af;
         v = VEC[i];
         case (v[24:22])
            3'd1: do_wr(v[21:20], 1'b0, v[19], v[18:3]);
            3'd2: do_wr(v[21:20], 1'b1, v[19], v[18:3]);
            3'd3: do_bst(v[21:20], v[18:3]);
            default: pulse_ready();
         endcase
         case (v[2:0])
            3'd1: ef = 5'b10000;
            3'd2: ef = 5'b01000;
            3'd3: ef = 5'b00100;
            3'd4: ef = 5'b00010;
            3'd5: ef = 5'b00001;
            default: ef = 5'b00000;
         endcase
         af = {fwd_valid, err_seq, err_class, err_size, err_busy};
         // R1 R2 R3 R4 R5 R6 R8 R12: exact flag pattern per row, at most one error
         check(af == ef, $sformatf("R2/R3/R4/R6/R8/R12 row %0d flags", i), 64'(af), 64'(ef));
         if (v[2:0] == 3'd6) check(desc_valid, $sformatf("R1/R5 row %0d desc_valid", i), 64'(desc_valid), 64'd1);
         if (v[2:0] == 3'd7) check(!desc_valid, $sformatf("R7 row %0d desc taken", i), 64'(desc_valid), 64'd0);
      end

      // R1 content and R7 hold
      do_reset();
      dma_mode = 1'b1;
      mt_set(16'h0140, 16'h1111, 16'h2222, 16'h3333);
      check(desc_valid && desc_data == 64'h3333_2222_1111_0140, "R1 descriptor",
            desc_data, 64'h3333_2222_1111_0140);
      repeat (3) @(negedge clk);
      check(desc_valid && desc_data == 64'h3333_2222_1111_0140, "R7 held without ready",
            desc_data, 64'h3333_2222_1111_0140);
      pulse_ready();
      check(!done_sts && !irq, "R9 no status before done", {62'd0, done_sts, irq}, 64'd0);
      pulse_done();
      check(done_sts && irq, "R9 done with INT=1", {62'd0, done_sts, irq}, 64'd3);
      repeat (2) @(negedge clk);
      check(irq, "R10 irq stays level", 64'(irq), 64'd1);
      pulse_clr();
      check(!done_sts && !irq, "R10 write-one-to-clear", {62'd0, done_sts, irq}, 64'd0);

      // R5 burst content, INT=0
      do_bst(2'd0, 16'h0004); do_bst(2'd1, 16'hA1A1);
      do_bst(2'd2, 16'hB2B2); do_bst(2'd3, 16'hC3C3);
      check(desc_valid && desc_data == 64'hC3C3_B2B2_A1A1_0004, "R5 burst descriptor",
            desc_data, 64'hC3C3_B2B2_A1A1_0004);
      pulse_ready();
      pulse_done();
      check(done_sts && !irq, "R9 done with INT=0", {62'd0, done_sts, irq}, 64'd2);
      pulse_clr();
      pulse_done();
      check(!done_sts, "R9 stray done ignored", 64'(done_sts), 64'd0);

      // R11 cache guard
      cache_req = 1'b1; cache_val = 4'h5; @(negedge clk); cache_req = 1'b0;
      check(cache_attr == 4'h5 && !cache_pend, "R11 idle update", 64'(cache_attr), 64'h5);
      do_bst(2'd0, 16'h0010); do_bst(2'd1, 16'h0); do_bst(2'd2, 16'h0); do_bst(2'd3, 16'h0);
      cache_req = 1'b1; cache_val = 4'h9; @(negedge clk); cache_req = 1'b0;
      check(cache_attr == 4'h5 && cache_pend, "R11 busy update deferred", 64'(cache_attr), 64'h5);
      pulse_ready();
      check(cache_attr == 4'h5, "R11 still busy while in flight", 64'(cache_attr), 64'h5);
      pulse_done();
      @(negedge clk);
      check(cache_attr == 4'h9 && !cache_pend, "R11 deferred update applied", 64'(cache_attr), 64'h9);
      pulse_clr();

      // R4 with DMA mode off
      dma_mode = 1'b0;
      @(negedge clk);
      do_wr(2'd2, 1'b1, 1'b0, 16'h0000);
      check(err_class, "R4 DMA word with mode off", 64'(err_class), 64'd1);
      do_bst(2'd0, 16'h0010);
      check(err_class, "R4 burst with mode off", 64'(err_class), 64'd1);
      do_wr(2'd1, 1'b0, 1'b0, 16'h0000);
      check(fwd_valid && !err_class, "R3 plain command with mode off", {62'd0, fwd_valid, err_class}, 64'd2);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule